// File: doc/BRIEF.md
# PUF Challenge Enrollment Classifier

This block runs the enrollment pass for a delay-based arbiter PUF. It takes candidate 64-bit challenges one at a time and sends each one to the PUF a fixed number of times. It counts how many of those evaluations answered 1. From the count it picks the majority answer as the challenge's reference bit. It also finds the number of evaluations that disagreed with that reference, called the mismatch count.

The mismatch count places the challenge in one of three classes:
- **Stable:** the count is at or below a low bound. The challenge is dropped.
- **Ultra-unstable:** the count is at or above a high bound, close to a coin flip. The challenge is dropped.
- **Sensitive:** the count lies between the two bounds. The challenge and its reference bit are written into a small reference table.

The table is later used to watch for environmental drift. Enrollment stops when the table fills or when the candidate marked as last has been judged.

The block reaches both the candidate source and the PUF through valid/ready handshakes. Only one PUF request is outstanding at a time. The response comes back as a single-cycle valid pulse after any latency, so a PUF model with variable timing can be attached.

Top module: `puf_enroll_classifier`

## Requirements
- R1: After reset, `done` is 0, `tbl_count` is 0, `tbl_wr_en` is 0, `puf_req_valid` is 0 and `cand_ready` is 1.
- R2: Each accepted candidate is sent to the PUF exactly REPS times (default 1000), and `puf_chal` carries that candidate for every request.
- R3: The reference bit is 1 only when strictly more than half of the REPS responses are 1. An exact tie gives reference 0.
- R4: The mismatch count is the number of responses that differ from the reference bit. A candidate whose mismatch count is at or below `lo_thresh` is stable and is not written.
- R5: A candidate that is not stable and whose mismatch count is at or above `hi_thresh` is ultra-unstable and is not written. The stable test takes priority over this one.
- R6: Any other candidate is written for exactly one cycle of `tbl_wr_en`. The write carries `{tbl_wr_ref, tbl_wr_chal}` at index `tbl_wr_idx`. Indices are 0, 1, 2, … in the order candidates arrive, and `tbl_count` rises by one per write.
- R7: The read port returns the challenge in `rd_chal` and the reference bit in `rd_ref` for the entry at `rd_idx`.
- R8: When the table holds DEPTH entries (default 8), `done` rises, `cand_ready` stays low and no further writes happen until reset.
- R9: After the candidate offered with `cand_last` = 1 has been judged, `done` is 1 and stays 1 until reset.
- R10: While `puf_req_valid` is high and `puf_req_ready` is low, `puf_req_valid` stays high and `puf_chal` does not change.
- R11: `cand_ready` is low while a candidate is being evaluated, and no PUF request is raised while `cand_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lo_thresh | input | CNT_W (10) | Stable bound on the mismatch count |
| hi_thresh | input | CNT_W (10) | Ultra-unstable bound on the mismatch count |
| cand_valid | input | 1 | Candidate offered |
| cand_ready | output | 1 | Block can take a candidate |
| cand_chal | input | CHAL_W (64) | Candidate challenge |
| cand_last | input | 1 | Marks the final candidate |
| puf_req_valid | output | 1 | PUF evaluation request |
| puf_req_ready | input | 1 | PUF accepts the request |
| puf_chal | output | CHAL_W (64) | Challenge sent to the PUF |
| puf_rsp_valid | input | 1 | One-cycle pulse: response available |
| puf_rsp_bit | input | 1 | PUF response bit |
| tbl_wr_en | output | 1 | Table write strobe |
| tbl_wr_idx | output | IDX_W (3) | Table index being written |
| tbl_wr_chal | output | CHAL_W (64) | Challenge being written |
| tbl_wr_ref | output | 1 | Reference bit being written |
| tbl_count | output | NUM_W (4) | Number of stored entries |
| rd_idx | input | IDX_W (3) | Read index |
| rd_chal | output | CHAL_W (64) | Stored challenge at `rd_idx` |
| rd_ref | output | 1 | Stored reference bit at `rd_idx` |
| done | output | 1 | Enrollment finished |

## Verification
The bench models the PUF as a source that returns a chosen number of 1s out of 1000, with random ready and response delays. This lets it aim candidates at the edges of each class:
- Mismatch counts exactly at `lo_thresh` and at `hi_thresh`, and one count inside each bound. A design that compares with the wrong strictness keeps or drops exactly these candidates.
- A 500/500 tie. Resolving the tie to 1 instead of 0 makes the mismatch count depend on the wrong reference.
- All-ones counts. A design that takes the ones count directly as the mismatch count would miss that these are stable.
- A ninth sensitive candidate offered to a full eight-entry table. A block that keeps accepting candidates, or wraps its write index, writes a ninth entry or raises `cand_ready`.

The number of requests per challenge is also counted. An off-by-one in the repetition counter shows up as 999 or 1001 requests.

// File: rtl/puf_enroll_pkg.sv
package puf_enroll_pkg;

  typedef enum logic [1:0] {
    CLS_STABLE = 2'd0,
    CLS_ULTRA  = 2'd1,
    CLS_KEEP   = 2'd2
  } cls_e;

  // Majority answer: 1 only with a strict majority of ones, a tie gives 0.
  function automatic logic majority_ref(input int unsigned ones,
                                        input int unsigned reps);
    return (ones * 2) > reps;
  endfunction

  // Number of responses that disagree with the chosen reference.
  function automatic int unsigned mismatch_of(input int unsigned ones,
                                              input int unsigned reps,
                                              input logic        ref_bit);
    return ref_bit ? (reps - ones) : ones;
  endfunction

  // Stable test is applied first, then the near-coin-flip test.
  function automatic cls_e classify(input int unsigned mism,
                                    input int unsigned lo,
                                    input int unsigned hi);
    if (mism <= lo)      return CLS_STABLE;
    else if (mism >= hi) return CLS_ULTRA;
    else                 return CLS_KEEP;
  endfunction

endpackage

// File: rtl/puf_eval_seq.sv
module puf_eval_seq #(
  parameter int CHAL_W = 64,
  parameter int REPS   = 1000,
  parameter int CNT_W  = $clog2(REPS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CHAL_W-1:0] chal_in,
  output logic              puf_req_valid,
  input  logic              puf_req_ready,
  output logic [CHAL_W-1:0] puf_chal,
  input  logic              puf_rsp_valid,
  input  logic              puf_rsp_bit,
  output logic              seq_done,
  output logic [CNT_W-1:0]  ones
);

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT} seq_st_e;

  seq_st_e            st;
  logic [CNT_W-1:0]   rcv;
  logic [CHAL_W-1:0]  chal_q;
  logic               last_rsp;

  assign last_rsp      = (rcv == CNT_W'(REPS - 1));
  assign puf_req_valid = (st == S_REQ);
  assign puf_chal      = chal_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      rcv      <= '0;
      ones     <= '0;
      chal_q   <= '0;
      seq_done <= 1'b0;
    end else begin
      seq_done <= 1'b0;
      unique case (st)
        S_IDLE: if (start) begin
          chal_q <= chal_in;
          rcv    <= '0;
          ones   <= '0;
          st     <= S_REQ;
        end
        S_REQ: if (puf_req_ready) st <= S_WAIT;
        S_WAIT: if (puf_rsp_valid) begin
          ones <= ones + CNT_W'(puf_rsp_bit);
          if (last_rsp) begin
            seq_done <= 1'b1;
            st       <= S_IDLE;
          end else begin
            rcv <= rcv + 1'b1;
            st  <= S_REQ;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R10: a pending request keeps its challenge until it is taken
  p_chal_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (puf_req_valid && !puf_req_ready) |=> (puf_req_valid && $stable(puf_chal)));

  // R2: the ones tally never runs ahead of the responses received
  p_ones_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_IDLE) |-> (ones <= rcv));

endmodule

// File: rtl/puf_class_judge.sv
module puf_class_judge
  import puf_enroll_pkg::*;
#(
  parameter int REPS  = 1000,
  parameter int CNT_W = $clog2(REPS + 1)
) (
  input  logic [CNT_W-1:0] ones,
  input  logic [CNT_W-1:0] lo_thresh,
  input  logic [CNT_W-1:0] hi_thresh,
  output logic             ref_bit,
  output cls_e             cls
);

  int unsigned mism;

  always_comb begin
    ref_bit = majority_ref(32'(ones), 32'(REPS));
    mism    = mismatch_of(32'(ones), 32'(REPS), ref_bit);
    cls     = classify(mism, 32'(lo_thresh), 32'(hi_thresh));
  end

endmodule

// File: rtl/puf_ref_table.sv
module puf_ref_table #(
  parameter int CHAL_W = 64,
  parameter int DEPTH  = 8,
  parameter int IDX_W  = $clog2(DEPTH),
  parameter int NUM_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CHAL_W-1:0] wr_chal,
  input  logic              wr_ref,
  output logic [NUM_W-1:0]  count,
  output logic              full,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [CHAL_W-1:0] rd_chal,
  output logic              rd_ref
);

  logic [CHAL_W:0] rd_vec [DEPTH];
  logic            do_wr;

  assign full  = (count == NUM_W'(DEPTH));
  assign do_wr = wr_en && !full;

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic [CHAL_W:0] ent;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              ent <= '0;
      else if (do_wr && count == NUM_W'(g))    ent <= {wr_ref, wr_chal};
    end
    assign rd_vec[g] = ent;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     count <= '0;
    else if (do_wr) count <= count + 1'b1;
  end

  assign {rd_ref, rd_chal} = rd_vec[rd_idx];

  // R8: the writer never offers an entry to a full table
  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (count < NUM_W'(DEPTH)));

endmodule

// File: rtl/puf_enroll_classifier.sv
module puf_enroll_classifier
  import puf_enroll_pkg::*;
#(
  parameter int CHAL_W = 64,
  parameter int REPS   = 1000,
  parameter int DEPTH  = 8,
  localparam int CNT_W = $clog2(REPS + 1),
  localparam int IDX_W = $clog2(DEPTH),
  localparam int NUM_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  lo_thresh,
  input  logic [CNT_W-1:0]  hi_thresh,
  input  logic              cand_valid,
  output logic              cand_ready,
  input  logic [CHAL_W-1:0] cand_chal,
  input  logic              cand_last,
  output logic              puf_req_valid,
  input  logic              puf_req_ready,
  output logic [CHAL_W-1:0] puf_chal,
  input  logic              puf_rsp_valid,
  input  logic              puf_rsp_bit,
  output logic              tbl_wr_en,
  output logic [IDX_W-1:0]  tbl_wr_idx,
  output logic [CHAL_W-1:0] tbl_wr_chal,
  output logic              tbl_wr_ref,
  output logic [NUM_W-1:0]  tbl_count,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [CHAL_W-1:0] rd_chal,
  output logic              rd_ref,
  output logic              done
);

  typedef enum logic [1:0] {T_GET, T_EVAL, T_JUDGE, T_DONE} top_st_e;

  top_st_e          st;
  logic             last_q;
  logic             start;
  logic             seq_done;
  logic [CNT_W-1:0] ones;
  logic             ref_bit;
  cls_e             cls;
  logic             tbl_full;
  logic             fills_now;

  assign cand_ready = (st == T_GET);
  assign start      = cand_ready && cand_valid;
  assign done       = (st == T_DONE);

  puf_eval_seq #(.CHAL_W(CHAL_W), .REPS(REPS), .CNT_W(CNT_W)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .chal_in      (cand_chal),
    .puf_req_valid(puf_req_valid),
    .puf_req_ready(puf_req_ready),
    .puf_chal     (puf_chal),
    .puf_rsp_valid(puf_rsp_valid),
    .puf_rsp_bit  (puf_rsp_bit),
    .seq_done     (seq_done),
    .ones         (ones)
  );

  puf_class_judge #(.REPS(REPS), .CNT_W(CNT_W)) u_judge (
    .ones     (ones),
    .lo_thresh(lo_thresh),
    .hi_thresh(hi_thresh),
    .ref_bit  (ref_bit),
    .cls      (cls)
  );

  assign tbl_wr_en   = (st == T_JUDGE) && (cls == CLS_KEEP) && !tbl_full;
  assign tbl_wr_idx  = tbl_count[IDX_W-1:0];
  assign tbl_wr_chal = puf_chal;
  assign tbl_wr_ref  = ref_bit;
  assign fills_now   = tbl_wr_en && (tbl_count == NUM_W'(DEPTH - 1));

  puf_ref_table #(.CHAL_W(CHAL_W), .DEPTH(DEPTH), .IDX_W(IDX_W), .NUM_W(NUM_W)) u_tbl (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (tbl_wr_en),
    .wr_chal(tbl_wr_chal),
    .wr_ref (tbl_wr_ref),
    .count  (tbl_count),
    .full   (tbl_full),
    .rd_idx (rd_idx),
    .rd_chal(rd_chal),
    .rd_ref (rd_ref)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= T_GET;
      last_q <= 1'b0;
    end else begin
      unique case (st)
        T_GET: if (start) begin
          last_q <= cand_last;
          st     <= T_EVAL;
        end
        T_EVAL:  if (seq_done) st <= T_JUDGE;
        T_JUDGE: st <= (last_q || fills_now || tbl_full) ? T_DONE : T_GET;
        default: st <= T_DONE;
      endcase
    end
  end

  // R11: no PUF traffic while the block waits for a candidate
  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cand_ready |-> !puf_req_valid);

  // R9: completion holds until reset
  p_done_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);

  // R8: a full table closes the candidate port
  p_full_closed_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tbl_count == NUM_W'(DEPTH)) |-> !cand_ready);

  // R6: each retained candidate produces a single-cycle write
  p_wr_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_wr_en |=> !tbl_wr_en);

endmodule

// File: tb/sim_puf_enroll_classifier.sv
`timescale 1ns/1ps
module sim_puf_enroll_classifier;

  localparam int CW    = 64;
  localparam int NREP  = 1000;
  localparam int DEP   = 8;
  localparam int STEP  = 337;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [9:0]    lo_thresh = 10'd100;
  logic [9:0]    hi_thresh = 10'd450;
  logic          cand_valid = 1'b0;
  logic          cand_ready;
  logic [CW-1:0] cand_chal = '0;
  logic          cand_last = 1'b0;
  logic          puf_req_valid;
  logic          puf_req_ready;
  logic [CW-1:0] puf_chal;
  logic          puf_rsp_valid;
  logic          puf_rsp_bit;
  logic          tbl_wr_en;
  logic [2:0]    tbl_wr_idx;
  logic [CW-1:0] tbl_wr_chal;
  logic          tbl_wr_ref;
  logic [3:0]    tbl_count;
  logic [2:0]    rd_idx = '0;
  logic [CW-1:0] rd_chal;
  logic          rd_ref;
  logic          done;

  always #2.5 clk = ~clk;

  puf_enroll_classifier #(.CHAL_W(CW), .REPS(NREP), .DEPTH(DEP)) u0 (
    .clk(clk), .rst_n(rst_n), .lo_thresh(lo_thresh), .hi_thresh(hi_thresh),
    .cand_valid(cand_valid), .cand_ready(cand_ready), .cand_chal(cand_chal),
    .cand_last(cand_last), .puf_req_valid(puf_req_valid),
    .puf_req_ready(puf_req_ready), .puf_chal(puf_chal),
    .puf_rsp_valid(puf_rsp_valid), .puf_rsp_bit(puf_rsp_bit),
    .tbl_wr_en(tbl_wr_en), .tbl_wr_idx(tbl_wr_idx), .tbl_wr_chal(tbl_wr_chal),
    .tbl_wr_ref(tbl_wr_ref), .tbl_count(tbl_count), .rd_idx(rd_idx),
    .rd_chal(rd_chal), .rd_ref(rd_ref), .done(done)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // ---------------- PUF model: exactly k ones in every 1000 evaluations
  int          k_of   [logic [CW-1:0]];
  int          idx_of [logic [CW-1:0]];
  logic [15:0] lf;
  bit          busy;
  int          dly;
  logic        rbit;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lf <= 16'hACE1; busy <= 0; dly <= 0; rbit <= 0;
      puf_req_ready <= 0; puf_rsp_valid <= 0; puf_rsp_bit <= 0;
    end else begin
      lf <= {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      puf_req_ready <= lf[1] | lf[4];
      puf_rsp_valid <= 1'b0;
      if (busy) begin
        if (dly == 0) begin
          puf_rsp_valid <= 1'b1;
          puf_rsp_bit   <= rbit;
          busy          <= 0;
        end else dly <= dly - 1;
      end else if (puf_req_valid && puf_req_ready) begin
        int i;
        i = idx_of.exists(puf_chal) ? idx_of[puf_chal] : 0;
        rbit <= ((i * STEP) % NREP) < (k_of.exists(puf_chal) ? k_of[puf_chal] : 0);
        idx_of[puf_chal] = i + 1;
        busy <= 1;
        dly  <= int'(lf[2]);
      end
    end
  end

  // ---------------- scoreboard
  typedef struct { logic [CW-1:0] chal; logic rbit; } exp_t;
  exp_t           expq[$];
  int             exp_idx = 0;
  int             kept = 0;
  logic [CW-1:0]  sent[$];

  // driver: computes class and reference from the requirements
  task automatic send(input logic [CW-1:0] c, input int k, input bit last);
    bit   r;
    int   m;
    r = (2 * k > NREP);                  // R3 strict majority, tie -> 0
    m = r ? NREP - k : k;                // R4 mismatch count
    if (m > int'(lo_thresh) && m < int'(hi_thresh) && kept < DEP) begin
      expq.push_back('{c, r});           // R6 retained
      kept++;
    end
    k_of[c] = k; idx_of[c] = 0; sent.push_back(c);
    @(negedge clk);
    cand_chal = c; cand_last = last; cand_valid = 1'b1;
    while (!cand_ready) @(negedge clk);
    @(negedge clk);
    cand_valid = 1'b0; cand_last = 1'b0;
    chk(cand_ready == 1'b0, "R11", "cand_ready during evaluation", cand_ready, 0);
    while (!cand_ready && !done) @(negedge clk);
  endtask

  // monitor: pops an expectation on every table write
  always @(negedge clk) begin
    if (rst_n && tbl_wr_en) begin
      if (expq.size() == 0) begin
        chk(0, "R4 R5 R8", "unexpected table write", tbl_wr_chal, 0);
      end else begin
        exp_t e;
        e = expq.pop_front();
        chk(tbl_wr_chal == e.chal, "R6", "written challenge", tbl_wr_chal, e.chal);
        chk(tbl_wr_ref == e.rbit, "R3", "written reference", tbl_wr_ref, e.rbit);
        chk(int'(tbl_wr_idx) == exp_idx, "R6", "write index", tbl_wr_idx, exp_idx);
        exp_idx++;
      end
    end
  end

  task automatic do_reset();
    rst_n = 1'b0;
    expq.delete(); exp_idx = 0; kept = 0; sent.delete();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic check_reps();
    foreach (sent[i])
      chk(idx_of[sent[i]] == NREP, "R2", "requests per challenge", idx_of[sent[i]], NREP);
  endtask

  // ---------------- watchdog
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000 && !finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=<190000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    chk(done == 0, "R1", "done after reset", done, 0);
    chk(tbl_count == 0, "R1", "count after reset", tbl_count, 0);
    chk(tbl_wr_en == 0, "R1", "write strobe after reset", tbl_wr_en, 0);
    chk(puf_req_valid == 0, "R1", "request after reset", puf_req_valid, 0);
    chk(cand_ready == 1, "R1", "cand_ready after reset", cand_ready, 1);

    // Phase A: class boundaries, lo=100 hi=450
    send(64'h0000_0000_0000_0A01, 0,    0); // R4 stable, no ones
    send(64'h0000_0000_0000_0A02, 1000, 0); // R4 stable, all ones
    send(64'h0000_0000_0000_0A03, 100,  0); // R4 mism == lo -> stable
    send(64'h0000_0000_0000_0A04, 101,  0); // keep, ref 0
    send(64'h0000_0000_0000_0A05, 899,  0); // keep, ref 1
    send(64'h0000_0000_0000_0A06, 500,  0); // R3 tie -> ref 0, R5 ultra
    send(64'h0000_0000_0000_0A07, 550,  0); // R5 mism == hi -> ultra
    send(64'h0000_0000_0000_0A08, 551,  0); // keep, ref 1, mism 449
    send(64'h0000_0000_0000_0A09, 449,  0); // keep, ref 0, mism 449
    send(64'h0000_0000_0000_0A0A, 501,  0); // R5 ultra
    send(64'h0000_0000_0000_0A0B, 300,  1); // keep, last
    @(negedge clk);
    chk(done == 1, "R9", "done after last candidate", done, 1);
    chk(tbl_count == 5, "R4 R5 R6", "entries kept", tbl_count, 5);
    chk(expq.size() == 0, "R6", "pending expected writes", expq.size(), 0);
    check_reps();
    begin
      logic [CW-1:0] ec [5] = '{64'hA04, 64'hA05, 64'hA08, 64'hA09, 64'hA0B};
      bit            er [5] = '{0, 1, 1, 0, 0};
      for (int i = 0; i < 5; i++) begin
        rd_idx = 3'(i);
        #1;
        chk(rd_chal == ec[i], "R7", "read challenge", rd_chal, ec[i]);
        chk(rd_ref == er[i], "R7", "read reference", rd_ref, er[i]);
      end
    end
    repeat (5) @(negedge clk);
    chk(done == 1, "R9", "done held", done, 1);

    // Phase B: fill the table, then offer one more
    do_reset();
    for (int i = 0; i < DEP; i++) send(64'hB000 + 64'(i), 300, 0);
    @(negedge clk);
    chk(done == 1, "R8", "done when full", done, 1);
    chk(tbl_count == 4'(DEP), "R8", "count when full", tbl_count, DEP);
    k_of[64'hB0FF] = 300; idx_of[64'hB0FF] = 0;
    cand_chal = 64'hB0FF; cand_valid = 1'b1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (i % 5 == 0)
        chk(cand_ready == 0, "R8", "cand_ready when full", cand_ready, 0);
    end
    cand_valid = 1'b0;
    chk(tbl_count == 4'(DEP), "R8", "count after extra offer", tbl_count, DEP);
    chk(idx_of[64'hB0FF] == 0, "R8", "requests for refused candidate", idx_of[64'hB0FF], 0);
    check_reps();

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule